// File: doc/BRIEF.md
# Double-to-single float store narrowing unit

This unit turns a 64-bit double-precision register image into the 32-bit single-precision word that a store writes to memory. A request is a 64-bit value with a one-cycle `req_valid` strobe. The result comes back on `out_word`, marked by a one-cycle `out_done` pulse. No rounding is done and no exception flags are raised. Every result is formed by selecting bits or by truncating shifts.

Inputs fall into three classes, chosen by the biased 11-bit exponent `e` (value bits 62:52, bit 63 is the sign):

- **Direct:** `e` > 896, or a magnitude of zero. This covers normal singles, zeros, infinities and NaNs. The word is built by picking bits and is ready one cycle after the request.
- **Denormal band:** `e` from 874 to 896. The value lands in the single-precision subnormal range. A 24-bit lead mantissa (a hidden one above value bits 51:29) is shifted right one place per clock. A signed working exponent, starting at `e` − 1023, rises by one on each shift until it reaches −126.
- **Underflow:** any other nonzero value. The word is all zeros.

Control is a three-state machine:

- **IDLE:** waiting for a request.
- **SHIFT:** the denormalization loop is running.
- **DONE:** `out_done` is high.

Its transitions are named as follows:

| Transition | Path | Taken when |
|---|---|---|
| ACCEPT_FAST | IDLE or DONE → DONE | a direct or underflow request is accepted |
| ACCEPT_SLOW | IDLE or DONE → SHIFT | a denormal-band request is accepted |
| SHIFT_MORE | SHIFT → SHIFT | this step does not bring the working exponent to −126 |
| SHIFT_LAST | SHIFT → DONE | this step brings the working exponent to −126 |
| RETIRE | DONE → IDLE | no new request arrives |

Top module: `fp_store_narrow`

## Requirements
- R1: After reset `out_done` is 0 and `out_word` is 0x00000000.
- R2: When `e` > 896, the word is {value[63], value[62], value[58:29]}, and `out_done` is high in the cycle after the request cycle. Examples: 0x4014000000000000 gives 0x40A00000, and 0x7FF0000000000000 gives 0x7F800000.
- R3: When value[62:0] is zero, the same bit mapping as R2 applies with the same one-cycle latency. The sign is kept, so 0x8000000000000000 gives 0x80000000.
- R4: When 874 ≤ `e` ≤ 896, the word is as follows:
  - bit 31 = value[63];
  - bits 30:23 = 0;
  - bits 22:0 = bits 22:0 of the 24-bit lead {1, value[51:29]} shifted right by 897 − `e`.
- R5: A denormal-band request raises `out_done` exactly 1 + (897 − `e`) cycles after its request cycle, so there are 1 to 23 shift steps.
- R6: A nonzero value with `e` < 874 gives 0x00000000, with `out_done` one cycle after the request.
- R7: `out_done` is high for one cycle only, unless a new direct or underflow request is accepted in that same cycle.
- R8: While `req_valid` is low and no shift loop is running, `out_word` keeps its value.
- R9: A `req_valid` pulse while a shift loop runs is ignored. It changes neither the result word nor the completion cycle of the running conversion.
- R10: A request presented in the cycle where `out_done` is high is accepted. The new result follows with its normal latency and needs no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| req_data | input | 64 | Double-precision bit pattern to narrow |
| out_done | output | 1 | One-cycle completion pulse |
| out_word | output | 32 | Single-precision store word |

## Verification
Two events can share a cycle: a completion pulse and the acceptance of the next request. In that cycle the DONE state both presents one result and loads the next. The bench provokes this by raising `req_valid` in the very cycle where `out_done` is seen high. It then expects `out_done` to stay high for a second cycle, now carrying the second word, and a clean one-cycle pulse to follow a slow second request. A related overlap is a request landing during SHIFT. This is driven with the inverted value, and the bench judges it by the unchanged word and completion cycle of the running conversion.

// File: rtl/fsn_pkg.sv
package fsn_pkg;

    localparam int DBL_W      = 64;
    localparam int SGL_W      = 32;
    localparam int DEXP_W     = 11;
    localparam int DFRAC_W    = 52;
    localparam int SEXP_W     = 8;
    localparam int SFRAC_W    = 23;
    localparam int WEXP_W     = DEXP_W + 1;
    localparam int DBL_BIAS   = 1023;
    localparam int SGL_EMIN   = -126;

    // exponent thresholds of the three classes
    localparam int DIRECT_MIN = DBL_BIAS + SGL_EMIN;       // 897
    localparam int DENORM_MIN = DIRECT_MIN - SFRAC_W;      // 874
    localparam int MAX_STEPS  = DIRECT_MIN - DENORM_MIN;   // 23
    localparam int LEAD_W     = SFRAC_W + 1;

    // bit selection of the direct mapping
    localparam int DIR_HI     = DBL_W - 3 - (DEXP_W - SEXP_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } state_t;

    typedef enum logic [1:0] {
        PATH_DIRECT = 2'd0,
        PATH_DENORM = 2'd1,
        PATH_ZERO   = 2'd2
    } path_t;

endpackage

// File: rtl/fsn_classify.sv
module fsn_classify
    import fsn_pkg::*;
(
    input  logic [DBL_W-1:0]         value,
    output path_t                    path,
    output logic [SGL_W-1:0]         direct_word,
    output logic                     sign,
    output logic [LEAD_W-1:0]        lead,
    output logic signed [WEXP_W-1:0] wexp
);

    logic [DEXP_W-1:0] bexp;
    logic              mag_zero;

    assign bexp     = value[DBL_W-2 -: DEXP_W];
    assign mag_zero = (value[DBL_W-2:0] == '0);
    assign sign     = value[DBL_W-1];

    // sign and top exponent bit, then low exponent bits and fraction
    assign direct_word = {value[DBL_W-1 -: 2], value[DIR_HI -: (SGL_W-2)]};

    // hidden one above the fraction bits that can reach the single field
    assign lead = {1'b1, value[DFRAC_W-1 -: SFRAC_W]};

    // unbiased working exponent
    assign wexp = WEXP_W'({1'b0, bexp}) - WEXP_W'(DBL_BIAS);

    always_comb begin
        if (mag_zero || (bexp >= DEXP_W'(DIRECT_MIN))) begin
            path = PATH_DIRECT;
        end else if (bexp >= DEXP_W'(DENORM_MIN)) begin
            path = PATH_DENORM;
        end else begin
            path = PATH_ZERO;
        end
    end

endmodule

// File: rtl/fsn_shifter.sv
module fsn_shifter
    import fsn_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic                     sign_in,
    input  logic [LEAD_W-1:0]        lead_in,
    input  logic signed [WEXP_W-1:0] wexp_in,
    output logic                     sign_q,
    output logic [SFRAC_W-1:0]       field,
    output logic                     last
);

    localparam logic signed [WEXP_W-1:0] STOP_M1 = WEXP_W'(SGL_EMIN - 1);

    logic [LEAD_W-1:0]        mant_q;
    logic signed [WEXP_W-1:0] wexp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mant_q <= '0;
            wexp_q <= '0;
            sign_q <= 1'b0;
        end else if (load) begin
            mant_q <= lead_in;
            wexp_q <= wexp_in;
            sign_q <= sign_in;
        end else if (step) begin
            mant_q <= {1'b0, mant_q[LEAD_W-1:1]};
            wexp_q <= wexp_q + WEXP_W'(1);
        end
    end

    // this step takes the working exponent to the single minimum
    assign last  = (wexp_q == STOP_M1);
    assign field = mant_q[SFRAC_W-1:0];

    // R4: every shift inserts a zero at the top of the lead mantissa
    a_r4_msb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (mant_q[LEAD_W-1] == 1'b0));

    // R5: the loop never steps past the single minimum exponent
    a_r5_exp_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && last) |=> (wexp_q == WEXP_W'(SGL_EMIN)));

endmodule

// File: rtl/fsn_ctrl.sv
module fsn_ctrl
    import fsn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_valid,
    input  path_t path,
    input  logic  last,
    output logic  load,
    output logic  step,
    output logic  cap_direct,
    output logic  in_shift,
    output logic  done
);

    localparam int LEN_W = $clog2(MAX_STEPS + 1) + 1;

    state_t state_q, state_d;
    logic   accept;

    assign accept = req_valid && (state_q != ST_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    // ACCEPT_SLOW / ACCEPT_FAST
                    state_d = (path == PATH_DENORM) ? ST_SHIFT : ST_DONE;
                end else begin
                    // RETIRE (or stay idle)
                    state_d = ST_IDLE;
                end
            end
            ST_SHIFT: begin
                // SHIFT_LAST / SHIFT_MORE
                state_d = last ? ST_DONE : ST_SHIFT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load       = accept && (path == PATH_DENORM);
        cap_direct = accept && (path != PATH_DENORM);
        step       = (state_q == ST_SHIFT);
        in_shift   = (state_q == ST_SHIFT);
        done       = (state_q == ST_DONE);
    end

    // checker counter: cycles spent in the shift loop
    logic [LEN_W-1:0] shift_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_len <= '0;
        end else if (state_q == ST_SHIFT) begin
            shift_len <= shift_len + LEN_W'(1);
        end else begin
            shift_len <= '0;
        end
    end

    a_r5_shift_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (shift_len < LEN_W'(MAX_STEPS)));

    a_r2_fast_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (state_q != ST_SHIFT) && (path != PATH_DENORM)) |=> done);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req_valid) |=> !done);

    a_r9_shift_ignores_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHIFT) && !last) |=> (state_q == ST_SHIFT));

    a_r10_accept_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid && (path == PATH_DENORM)) |=> (state_q == ST_SHIFT));

endmodule

// File: rtl/fp_store_narrow.sv
module fp_store_narrow
    import fsn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DBL_W-1:0] req_data,
    output logic             out_done,
    output logic [SGL_W-1:0] out_word
);

    path_t                    path;
    logic [SGL_W-1:0]         direct_word;
    logic                     in_sign;
    logic [LEAD_W-1:0]        lead;
    logic signed [WEXP_W-1:0] wexp;
    logic                     load, step, cap_direct, in_shift, last;
    logic                     sign_q;
    logic [SFRAC_W-1:0]       field;
    logic [SGL_W-1:0]         word_q;
    logic                     den_sel_q;

    fsn_classify u_classify (
        .value       (req_data),
        .path        (path),
        .direct_word (direct_word),
        .sign        (in_sign),
        .lead        (lead),
        .wexp        (wexp)
    );

    fsn_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .path       (path),
        .last       (last),
        .load       (load),
        .step       (step),
        .cap_direct (cap_direct),
        .in_shift   (in_shift),
        .done       (out_done)
    );

    fsn_shifter u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .sign_in (in_sign),
        .lead_in (lead),
        .wexp_in (wexp),
        .sign_q  (sign_q),
        .field   (field),
        .last    (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            den_sel_q <= 1'b0;
        end else if (cap_direct) begin
            word_q    <= (path == PATH_ZERO) ? '0 : direct_word;
            den_sel_q <= 1'b0;
        end else if (load) begin
            den_sel_q <= 1'b1;
        end
    end

    assign out_word = den_sel_q ? {sign_q, {SEXP_W{1'b0}}, field} : word_q;

    // R8: the word is stable while nothing is accepted and no loop runs
    a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !in_shift) |=> $stable(out_word));

    // R6: an accepted underflow request completes with an all-zero word
    a_r6_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_direct && (path == PATH_ZERO)) |=> (out_done && (out_word == '0)));

endmodule

// File: tb/tb_fp_store_narrow.sv
module tb_fp_store_narrow;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_data = '0;
    logic        out_done;
    logic [31:0] out_word;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    fp_store_narrow dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_data  (req_data),
        .out_done  (out_done),
        .out_word  (out_word)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL R5 watchdog expired: actual %0d cycles, expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int ex_of(input logic [63:0] v);
        return int'(v[62:52]);
    endfunction

    function automatic logic [31:0] ref_word(input logic [63:0] v);
        int          e;
        logic [23:0] m;
        e = ex_of(v);
        if (e > 896 || v[62:0] == '0) return {v[63], v[62], v[58:29]};
        if (e >= 874) begin
            m = {1'b1, v[51:29]} >> (897 - e);
            return {v[63], 8'h00, m[22:0]};
        end
        return 32'h0;
    endfunction

    function automatic int ref_lat(input logic [63:0] v);
        int e;
        e = ex_of(v);
        if (v[62:0] != '0 && e >= 874 && e <= 896) return 1 + (897 - e);
        return 1;
    endfunction

    function automatic string tag_of(input logic [63:0] v);
        int e;
        e = ex_of(v);
        if (v[62:0] == '0) return "R3";
        if (e > 896)       return "R2";
        if (e >= 874)      return "R4";
        return "R6";
    endfunction

    // one conversion; optional stray request during the shift loop (R9)
    task automatic convert(input logic [63:0] v, input bit noise);
        logic [31:0] ew;
        int          el;
        int          n;
        bit          stray;
        ew = ref_word(v);
        el = ref_lat(v);
        stray = noise && (el > 2);
        @(negedge clk);
        req_valid = 1'b1;
        req_data  = v;
        @(negedge clk);
        n = 1;
        req_valid = stray;
        req_data  = ~v;
        while (!out_done && n < 40) begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end
        req_valid = 1'b0;
        check(n == el, stray ? "R9 latency with stray request" : "R5 latency",
              64'(n), 64'(el));
        check(out_word == ew, stray ? "R9 word with stray request" : tag_of(v),
              64'(out_word), 64'(ew));
        @(negedge clk);
        check(out_done == 1'b0, "R7 done pulse", 64'(out_done), 64'd0);
    endtask

    function automatic logic [63:0] rand_value();
        logic [10:0] e;
        logic [51:0] f;
        int          k;
        f = {20'($urandom), $urandom};
        k = int'($urandom % 4);
        case (k)
            0:       e = 11'(897 + ($urandom % 1151));
            1:       e = 11'(874 + ($urandom % 23));
            2:       begin e = 11'($urandom % 874); f[0] = 1'b1; end
            default: begin e = ($urandom % 2 == 0) ? 11'h7FF : 11'h000;
                           if ($urandom % 2 == 0) f = '0; end
        endcase
        return {1'($urandom), e, f};
    endfunction

    initial begin
        logic [31:0] held;
        logic [63:0] a;
        logic [63:0] b;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_done == 1'b0, "R1 reset done", 64'(out_done), 64'd0);
        check(out_word == 32'h0, "R1 reset word", 64'(out_word), 64'd0);

        // directed corner cases
        convert(64'h4014000000000000, 1'b0);            // R2 -> 0x40A00000
        check(out_word == 32'h40A00000, "R2 vector 5.0", 64'(out_word), 64'h40A00000);
        convert(64'h7FF0000000000000, 1'b0);            // R2 infinity
        convert(64'h3810000000000000, 1'b0);            // R2 e=897 smallest normal
        convert(64'h0000000000000000, 1'b0);            // R3 +0
        convert(64'h8000000000000000, 1'b0);            // R3 -0
        convert({1'b0, 11'd873, 52'h1}, 1'b0);          // R6 just below band
        convert({1'b0, 11'd896, 52'h0}, 1'b0);          // R4 top of band
        convert({1'b1, 11'd874, {52{1'b1}}}, 1'b0);     // R4 bottom of band, 23 steps
        convert({1'b0, 11'd880, 52'hABCDE12345678}, 1'b1); // R9 stray request

        // R8: word held while idle
        held = out_word;
        repeat (4) @(negedge clk);
        check(out_word == held, "R8 idle hold", 64'(out_word), 64'(held));

        // R10: second request presented in the done cycle
        a = 64'h4014000000000000;
        b = 64'hC000000000000000;
        @(negedge clk);
        req_valid = 1'b1; req_data = a;
        @(negedge clk);
        req_valid = 1'b1; req_data = b;                 // done for a is high now
        check(out_done == 1'b1 && out_word == ref_word(a), "R10 first result",
              64'(out_word), 64'(ref_word(a)));
        @(negedge clk);
        req_valid = 1'b0;
        check(out_done == 1'b1 && out_word == ref_word(b), "R10 back-to-back result",
              64'(out_word), 64'(ref_word(b)));
        @(negedge clk);
        check(out_done == 1'b0, "R7 done after back-to-back", 64'(out_done), 64'd0);

        // R10: slow request accepted in the done cycle
        b = {1'b0, 11'd890, 52'h123456789ABCD};
        @(negedge clk);
        req_valid = 1'b1; req_data = a;
        @(negedge clk);
        req_valid = 1'b1; req_data = b;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_done == 1'b0, "R10 slow follow-up in loop", 64'(out_done), 64'd0);
        repeat (ref_lat(b) - 1) @(negedge clk);
        check(out_done == 1'b1 && out_word == ref_word(b), "R10 slow follow-up result",
              64'(out_word), 64'(ref_word(b)));
        @(negedge clk);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            convert(rand_value(), ($urandom % 4) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule